// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Register

This block keeps the next output pattern for the upper byte of a pattern port, split into two four-bit groups. The high group drives port bits 15 to 12 and the low group drives port bits 11 to 8. A processor loads the pattern ahead of time over a byte-wide bus. When the selected timer compare-match strobe arrives, the staged nibble of each affected group is copied into the port data bits. The port therefore changes exactly on the timer event, with no processor delay in the path.

The two groups can share one trigger, or each group can follow its own trigger. The `shared_mode` input chooses between the two. It also changes how the two byte addresses of the staging register decode:

- **Shared mode:** one byte holds both nibbles, and the other address is reserved.
- **Separate mode:** each address exposes one group's nibble, and the other half of that byte reads as ones.

A per-group enable blocks transfers to port bits that are not used for pattern output. The processor can also write the port bits directly in cycles where no transfer touches them.

Top module: `pattern_stage_reg`

## Requirements
- R1: After `rst_n` is released, the staging register and `port_q` are both 0x00. In shared mode, a read of address 0 returns 0x00.
- R2: In shared mode, address 0 (`cpu_addr`=0) reads and writes the whole staging byte. Bits 7:4 are the high group and bits 3:0 are the low group. When `cpu_sel` is low, `cpu_rdata` is 0x00.
- R3: In shared mode, address 1 reads as 0xFF. A write to address 1 leaves both staged nibbles unchanged.
- R4: In separate mode, address 0 reads as {high nibble, 4'hF}, and a write to it updates only the high nibble from `cpu_wdata[7:4]`. Address 1 reads as {4'hF, low nibble}, and a write to it updates only the low nibble from `cpu_wdata[3:0]`.
- R5: A transfer copies a staged nibble into its port bits at the clock edge where the strobe is sampled. The high nibble goes to `port_q[7:4]` and the low nibble goes to `port_q[3:0]`. The new value is visible after that edge.
- R6: In shared mode, `cmp_hi` triggers both groups in the same cycle, and `cmp_lo` has no effect.
- R7: In separate mode, `cmp_hi` triggers only the high group and `cmp_lo` triggers only the low group.
- R8: A group whose enable (`oe_hi` or `oe_lo`) is low ignores its trigger, and its port bits keep their value.
- R9: When a staging write and a transfer fall in the same cycle, the port receives the previously staged value. The staging register then holds the written value.
- R10: `port_we` writes `port_wdata` into the port nibbles that have no transfer in that cycle. On a nibble that has a transfer, the transfer wins.
- R11: The staging register and the port bits hold their values indefinitely without access. Only `rst_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| shared_mode | input | 1 | 1: both groups use `cmp_hi`; 0: separate triggers |
| cpu_sel | input | 1 | Access strobe for the staging register addresses |
| cpu_addr | input | 1 | Byte address within the staging pair |
| cpu_we | input | 1 | Write when selected |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| port_we | input | 1 | Direct write of port data bits |
| port_wdata | input | 8 | Direct port write data |
| cmp_hi | input | 1 | Compare-match strobe for the high group |
| cmp_lo | input | 1 | Compare-match strobe for the low group |
| oe_hi | input | 1 | Pattern output enable, high group |
| oe_lo | input | 1 | Pattern output enable, low group |
| port_q | output | 8 | Port data bits 15..8 |

## Verification
The bench builds the block with its default nibble width of four, which is the only width where the reserved reads, the half-byte reads in separate mode and the two-group split all match the requirements. At that width, every combination of mode, strobe, enable and collision fits in a short directed sequence. A behavioural model is checked against the design on every clock. That brings within reach the collision cycles where a staging write, a direct port write and a transfer coincide on one or both nibbles.

// File: rtl/pattern_stage_reg.sv
module pattern_stage_reg #(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shared_mode,
  input  logic                 cpu_sel,
  input  logic                 cpu_addr,
  input  logic                 cpu_we,
  input  logic [2*NIB_W-1:0]   cpu_wdata,
  output logic [2*NIB_W-1:0]   cpu_rdata,
  input  logic                 port_we,
  input  logic [2*NIB_W-1:0]   port_wdata,
  input  logic                 cmp_hi,
  input  logic                 cmp_lo,
  input  logic                 oe_hi,
  input  logic                 oe_lo,
  output logic [2*NIB_W-1:0]   port_q
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] ONES = '1;

  logic [NIB_W-1:0] stg_hi, stg_lo;
  logic [NIB_W-1:0] prt_hi, prt_lo;

  logic wr_a0, wr_a1, ld_hi, ld_lo;
  logic go_hi, go_lo;

  assign wr_a0 = cpu_sel & cpu_we & ~cpu_addr;
  assign wr_a1 = cpu_sel & cpu_we &  cpu_addr;
  assign ld_hi = wr_a0;
  assign ld_lo = shared_mode ? wr_a0 : wr_a1;

  assign go_hi = cmp_hi & oe_hi;
  assign go_lo = (shared_mode ? cmp_hi : cmp_lo) & oe_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_hi <= '0;
      stg_lo <= '0;
    end else begin
      if (ld_hi) stg_hi <= cpu_wdata[BYTE_W-1:NIB_W];
      if (ld_lo) stg_lo <= cpu_wdata[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prt_hi <= '0;
      prt_lo <= '0;
    end else begin
      if (go_hi)        prt_hi <= stg_hi;
      else if (port_we) prt_hi <= port_wdata[BYTE_W-1:NIB_W];
      if (go_lo)        prt_lo <= stg_lo;
      else if (port_we) prt_lo <= port_wdata[NIB_W-1:0];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_sel) begin
      if (shared_mode) cpu_rdata = cpu_addr ? {ONES, ONES} : {stg_hi, stg_lo};
      else             cpu_rdata = cpu_addr ? {ONES, stg_lo} : {stg_hi, ONES};
    end
  end

  assign port_q = {prt_hi, prt_lo};

  // R3
  reserved_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_mode && cpu_sel && cpu_we && cpu_addr) |=> ($stable(stg_hi) && $stable(stg_lo)));

  // R5
  hi_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hi && oe_hi) |=> (port_q[BYTE_W-1:NIB_W] == $past(stg_hi)));

  // R6
  shared_lo_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_mode && cmp_hi && oe_lo) |=> (port_q[NIB_W-1:0] == $past(stg_lo)));

  // R8
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_lo && !port_we) |=> $stable(port_q[NIB_W-1:0]));

  // R8
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_hi && !port_we) |=> $stable(port_q[BYTE_W-1:NIB_W]));

  // R10
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we && !cmp_hi) |=> (port_q[BYTE_W-1:NIB_W] == $past(port_wdata[BYTE_W-1:NIB_W])));

  // R11
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_sel && cpu_we) |=> ($stable(stg_hi) && $stable(stg_lo)));
endmodule

// File: tb/sim_pattern_stage_reg.sv
module sim_pattern_stage_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shared_mode = 1'b1;
  logic cpu_sel = 1'b0, cpu_addr = 1'b0, cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic port_we = 1'b0;
  logic [7:0] port_wdata = '0;
  logic cmp_hi = 1'b0, cmp_lo = 1'b0, oe_hi = 1'b0, oe_lo = 1'b0;
  logic [7:0] port_q;

  int errors = 0;
  int checks = 0;

  logic [3:0] m_hi = '0, m_lo = '0;
  logic [7:0] m_port = '0;

  always #4 clk = ~clk;

  pattern_stage_reg u0 (
    .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
    .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .port_we(port_we), .port_wdata(port_wdata),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .oe_hi(oe_hi), .oe_lo(oe_lo),
    .port_q(port_q)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read();
    if (!cpu_sel) return 8'h00;
    if (shared_mode) return cpu_addr ? 8'hFF : {m_hi, m_lo};
    return cpu_addr ? {4'hF, m_lo} : {m_hi, 4'hF};
  endfunction

  task automatic model_clock();
    logic th, tl;
    th = cmp_hi && oe_hi;
    tl = (shared_mode ? cmp_hi : cmp_lo) && oe_lo;
    if (th) m_port[7:4] = m_hi;
    else if (port_we) m_port[7:4] = port_wdata[7:4];
    if (tl) m_port[3:0] = m_lo;
    else if (port_we) m_port[3:0] = port_wdata[3:0];
    if (cpu_sel && cpu_we) begin
      if (shared_mode) begin
        if (!cpu_addr) begin m_hi = cpu_wdata[7:4]; m_lo = cpu_wdata[3:0]; end
      end else if (!cpu_addr) m_hi = cpu_wdata[7:4];
      else m_lo = cpu_wdata[3:0];
    end
  endtask

  task automatic step(input string tag, input logic sh, input logic sel, input logic ad,
                      input logic we, input logic [7:0] wd, input logic pwe, input logic [7:0] pwd,
                      input logic ch, input logic cl, input logic eh, input logic el);
    shared_mode = sh; cpu_sel = sel; cpu_addr = ad; cpu_we = we; cpu_wdata = wd;
    port_we = pwe; port_wdata = pwd; cmp_hi = ch; cmp_lo = cl; oe_hi = eh; oe_lo = el;
    #1;
    chk(tag, "rdata", cpu_rdata, model_read());
    @(posedge clk);
    model_clock();
    @(negedge clk);
    chk(tag, "port", port_q, m_port);
  endtask

  task automatic rd(input string tag, input logic sh, input logic ad);
    step(tag, sh, 1, ad, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "port after reset", port_q, 8'h00);
    rd("R1", 1, 0);
    // R2 shared full-byte access and deselected read
    step("R2", 1, 1, 0, 1, 8'hA5, 0, 8'h00, 0, 0, 0, 0);
    rd("R2", 1, 0);
    step("R2", 1, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0);
    // R3 reserved address
    rd("R3", 1, 1);
    step("R3", 1, 1, 1, 1, 8'h3C, 0, 8'h00, 0, 0, 0, 0);
    rd("R3", 1, 0);
    // R5 / R6 shared transfer, cmp_lo ignored
    step("R6", 1, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, 1, 1);
    step("R5", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 1, 1);
    step("R2", 1, 1, 0, 1, 8'h7E, 0, 8'h00, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 1, 1);
    // R8 enable gating
    step("R2", 1, 1, 0, 1, 8'h19, 0, 8'h00, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 1, 0);
    step("R8", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 0, 1);
    step("R8", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 0, 0);
    // R4 separate mode decode
    rd("R4", 0, 0);
    rd("R4", 0, 1);
    step("R4", 0, 1, 0, 1, 8'hC3, 0, 8'h00, 0, 0, 0, 0);
    rd("R4", 0, 0);
    rd("R4", 0, 1);
    step("R4", 0, 1, 1, 1, 8'hD6, 0, 8'h00, 0, 0, 0, 0);
    rd("R4", 0, 0);
    rd("R4", 0, 1);
    rd("R4", 1, 0);
    // R7 separate triggers
    step("R7", 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, 1, 1);
    step("R7", 0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 1, 1);
    step("R4", 0, 1, 0, 1, 8'h20, 0, 8'h00, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 1, 1);
    // R9 collisions
    step("R9", 1, 1, 0, 1, 8'hE1, 0, 8'h00, 1, 0, 1, 1);
    rd("R9", 1, 0);
    step("R9", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 1, 1);
    step("R9", 0, 1, 1, 1, 8'h0B, 0, 8'h00, 0, 1, 1, 1);
    rd("R9", 0, 1);
    // R10 direct port writes and priority
    step("R10", 1, 0, 0, 0, 8'h00, 1, 8'h5A, 0, 0, 1, 1);
    step("R10", 0, 0, 0, 0, 8'h00, 1, 8'hC3, 1, 0, 1, 1);
    step("R10", 0, 0, 0, 0, 8'h00, 1, 8'h96, 0, 1, 1, 1);
    step("R10", 1, 0, 0, 0, 8'h00, 1, 8'h44, 1, 0, 1, 1);
    step("R10", 0, 0, 0, 0, 8'h00, 1, 8'h81, 1, 1, 0, 0);
    // R11 hold without access
    step("R2", 1, 1, 0, 1, 8'h6D, 0, 8'h00, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step("R11", i[0], 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0);
    rd("R11", 1, 0);
    step("R11", 1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 1, 1);
    // R1 reset clears everything again
    rst_n = 1'b0;
    @(negedge clk);
    m_hi = '0; m_lo = '0; m_port = '0;
    chk("R1", "port in reset", port_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule